// File: doc/BRIEF.md
# Event Timer Register Front End and Main Counter

This block is the register face of a multi-timer event timer. It exposes a small memory-mapped space over a simple valid/address/data port. Part of that space is global: a read-only capability word, a configuration word holding the global enable and the legacy-routing bit, an interrupt status word and the free-running 64-bit main counter. The rest is one window per timer channel. The block owns the configuration bits and the main counter. It only decodes accesses to the per-timer windows and to the status word. Writes there leave the block as one-cycle strobes, with the write data and byte-lane mask already shifted into place. Reads there are served from the comparator logic's own register outputs.

Every register is 64 bits wide and can be reached by a full 8-byte access or by a 4-byte access. For a 4-byte access, address bit 2 selects the upper half. The main counter advances by one per clock while the global enable is set. When the enable is cleared the counter freezes, and it resumes from the held value when the enable is set again. Software may overwrite the counter at any time, in halves or whole.

Top module: `evtimer_regs`

## Requirements
- R1: After reset the main counter reads 0, and both configuration bits (enable and legacy) are 0.
- R2: The capability word at offset 0x000 reads as follows. The low half is 0x8086A001 with bits 12:8 replaced by NUM_TIMERS-1. The upper half is TICK_FS, the tick period in femtoseconds. Writes to it have no effect.
- R3: Address bit 2 selects the register half. A read returns the 64-bit register shifted right by 32 when bit 2 is set. A 4-byte write changes only the addressed half, taking its data from bus_wdata[31:0]. An 8-byte write at an address with bit 2 clear changes all 64 bits.
- R4: The configuration word sits at offset 0x010. Only bit 0 (global enable) and bit 1 (legacy routing) are writable. All other bits read 0, and writing them changes nothing.
- R5: While the enable is 1, the counter increases by exactly 1 each clock. While the enable is 0, it keeps its value, and reads at offset 0x0F0 return that held value.
- R6: The counter at offset 0x0F0 is writable by 4-byte or 8-byte access, whether the enable is set or not. In the write cycle the written bits replace the increment. Counting resumes from the new value on the next clock.
- R7: Global offsets other than 0x000, 0x010, 0x020 and 0x0F0 read 0, and writes to them change no state. Accesses with address bits 1:0 not zero are also treated as unmapped.
- R8: The status word at offset 0x020 reads tmr_status in bits NUM_TIMERS-1:0. A write there drives status_clr with the written one-bits for that write cycle only.
- R9: Timer n's window starts at 0x100 + 0x20*n. Its configuration register is at +0x00, its comparator at +0x08 and its route register at +0x10, and reads return the matching tmr_*_q slice. A write there pulses exactly one of tmr_wr_cfg, tmr_wr_cmp or tmr_wr_route, at bit n, during the write cycle. tmr_wdata carries the data shifted into place, and tmr_wmask carries the lane mask. Offset +0x18 reads 0 and pulses nothing.
- R10: A window whose timer number is NUM_TIMERS or higher reads 0, and writes to it raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 64 | Write data, right-aligned |
| bus_rdata | output | 64 | Read data for bus_addr (combinational) |
| tmr_status | input | NUM_TIMERS | Per-timer interrupt status from the comparator logic |
| tmr_cfg_q | input | 64*NUM_TIMERS | Per-timer configuration register contents |
| tmr_cmp_q | input | 64*NUM_TIMERS | Per-timer comparator register contents |
| tmr_route_q | input | 64*NUM_TIMERS | Per-timer route register contents |
| glb_enable | output | 1 | Global enable bit |
| glb_legacy | output | 1 | Legacy routing bit |
| ctr_value | output | 64 | Main counter |
| tmr_wr_cfg | output | NUM_TIMERS | Timer configuration write strobes |
| tmr_wr_cmp | output | NUM_TIMERS | Timer comparator write strobes |
| tmr_wr_route | output | NUM_TIMERS | Timer route write strobes |
| tmr_wdata | output | 64 | Write data shifted to the addressed half |
| tmr_wmask | output | 64 | Bit mask of the written half or halves |
| status_clr | output | NUM_TIMERS | Status bits written as one |

## Verification
Several properties are checked on every cycle. The counter steps by one, or holds, in every cycle without a write, depending on the enable. The configuration bits change only through a write, and at most one timer strobe is ever active. No strobe or status-clear bit appears without a write, and the capability low half is always visible at offset 0. Other behaviour depends on chosen addresses and data, and only the bench's scenarios show it. This covers where a half-word write lands, writes that carry across the 32-bit boundary of the counter, and a write that overrides the increment. It also covers the reserved configuration bits, unmapped and out-of-range windows, and the values read back from each window.

// File: rtl/evtimer_regs_pkg.sv
package evtimer_regs_pkg;
   localparam int REG_W  = 64;
   localparam int HALF_W = 32;
   localparam int CFG_W  = 2;
   localparam logic [CFG_W-1:0] CFG_WR_MASK = 2'b11;
   localparam logic [HALF_W-1:0] CAP_BASE  = 32'h8086_A001;

   typedef enum logic [2:0] {
      RK_NONE,
      RK_CAP,
      RK_CFG,
      RK_STAT,
      RK_CTR,
      RK_TCFG,
      RK_TCMP,
      RK_TROUTE
   } reg_kind_e;

   // Bits covered by an access: 4-byte accesses cover one half, 8-byte both.
   function automatic logic [REG_W-1:0] lane_mask(input logic wide, input logic hi);
      logic [REG_W-1:0] m;
      m = wide ? {REG_W{1'b1}} : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
      return hi ? (m << HALF_W) : m;
   endfunction
endpackage

// File: rtl/evtimer_addr_dec.sv
module evtimer_addr_dec
   import evtimer_regs_pkg::*;
#(
   parameter int NUM_TIMERS = 3,
   parameter int ADDR_W     = 10,
   localparam int TID_W     = ADDR_W - 5
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_kind_e         kind,
   output logic [TID_W-1:0]  tid,
   output logic              hi
);
   localparam logic [ADDR_W-1:0] WIN_BASE = ADDR_W'(12'h100);

   logic [ADDR_W-1:0] off;
   logic [7:0]        gofs;

   assign hi   = addr[2];
   assign off  = addr - WIN_BASE;
   assign tid  = off[ADDR_W-1:5];
   assign gofs = {addr[7:3], 1'b0, addr[1:0]};

   always_comb begin
      kind = RK_NONE;
      if (addr[1:0] != 2'b00) begin
         kind = RK_NONE;
      end else if (addr < WIN_BASE) begin
         unique case (gofs)
            8'h00:   kind = RK_CAP;
            8'h10:   kind = RK_CFG;
            8'h20:   kind = RK_STAT;
            8'hF0:   kind = RK_CTR;
            default: kind = RK_NONE;
         endcase
      end else if (int'(tid) < NUM_TIMERS) begin
         unique case (off[4:3])
            2'd0:    kind = RK_TCFG;
            2'd1:    kind = RK_TCMP;
            2'd2:    kind = RK_TROUTE;
            default: kind = RK_NONE;
         endcase
      end
   end
endmodule

// File: rtl/evtimer_glb_cfg.sv
module evtimer_glb_cfg #(
   parameter int W = 2,
   parameter logic [W-1:0] WR_MASK = '1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         wr,
   input  logic [W-1:0] wmask,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] cfg_q
);
   logic [W-1:0] eff_mask;
   assign eff_mask = wmask & WR_MASK;

   always_ff @(posedge clk) begin
      if (rst)     cfg_q <= '0;
      else if (wr) cfg_q <= (cfg_q & ~eff_mask) | (wdata & eff_mask);
   end
endmodule

// File: rtl/evtimer_main_ctr.sv
module evtimer_main_ctr #(
   parameter int W = 64
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         run,
   input  logic         wr,
   input  logic [W-1:0] wmask,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] count
);
   always_ff @(posedge clk) begin
      if (rst)      count <= '0;
      else if (wr)  count <= (count & ~wmask) | (wdata & wmask);
      else if (run) count <= count + W'(1);
   end
endmodule

// File: rtl/evtimer_regs.sv
module evtimer_regs
   import evtimer_regs_pkg::*;
#(
   parameter int NUM_TIMERS = 3,
   parameter int ADDR_W     = 10,
   parameter int unsigned TICK_FS = 32'd10_000_000,
   localparam int TID_W     = ADDR_W - 5,
   localparam int TBUS_W    = NUM_TIMERS * REG_W
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  bus_valid,
   input  logic                  bus_write,
   input  logic                  bus_wide,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [REG_W-1:0]      bus_wdata,
   output logic [REG_W-1:0]      bus_rdata,
   input  logic [NUM_TIMERS-1:0] tmr_status,
   input  logic [TBUS_W-1:0]     tmr_cfg_q,
   input  logic [TBUS_W-1:0]     tmr_cmp_q,
   input  logic [TBUS_W-1:0]     tmr_route_q,
   output logic                  glb_enable,
   output logic                  glb_legacy,
   output logic [REG_W-1:0]      ctr_value,
   output logic [NUM_TIMERS-1:0] tmr_wr_cfg,
   output logic [NUM_TIMERS-1:0] tmr_wr_cmp,
   output logic [NUM_TIMERS-1:0] tmr_wr_route,
   output logic [REG_W-1:0]      tmr_wdata,
   output logic [REG_W-1:0]      tmr_wmask,
   output logic [NUM_TIMERS-1:0] status_clr
);
   localparam logic [HALF_W-1:0] CAP_LO  = CAP_BASE | (HALF_W'(NUM_TIMERS - 1) << 8);
   localparam logic [REG_W-1:0]  CAP_VAL = {TICK_FS[HALF_W-1:0], CAP_LO};

   // Elaboration-time parameter checks
   if (NUM_TIMERS < 1 || NUM_TIMERS > 32) begin : g_bad_count
      $error("NUM_TIMERS must lie in 1..32");
   end
   if (ADDR_W < 9 || (256 + 32 * NUM_TIMERS) > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too small for the timer windows");
   end
   if (TICK_FS == 0) begin : g_bad_tick
      $error("TICK_FS must be non-zero");
   end

   reg_kind_e          kind;
   logic [TID_W-1:0]   tid;
   logic               hi;
   logic               wr_go;
   logic [REG_W-1:0]   placed;
   logic [REG_W-1:0]   lanes;
   logic [REG_W-1:0]   clr_bits;
   logic [CFG_W-1:0]   cfg_bits;
   logic [REG_W-1:0]   reg_val;

   evtimer_addr_dec #(
      .NUM_TIMERS(NUM_TIMERS),
      .ADDR_W    (ADDR_W)
   ) u_dec (
      .addr(bus_addr),
      .kind(kind),
      .tid (tid),
      .hi  (hi)
   );

   assign wr_go    = bus_valid && bus_write;
   assign lanes    = lane_mask(bus_wide, hi);
   assign placed   = hi ? (bus_wdata << HALF_W) : bus_wdata;
   assign clr_bits = placed & lanes;

   evtimer_glb_cfg #(
      .W      (CFG_W),
      .WR_MASK(CFG_WR_MASK)
   ) u_cfg (
      .clk  (clk),
      .rst  (rst),
      .wr   (wr_go && kind == RK_CFG),
      .wmask(lanes[CFG_W-1:0]),
      .wdata(placed[CFG_W-1:0]),
      .cfg_q(cfg_bits)
   );

   assign glb_enable = cfg_bits[0];
   assign glb_legacy = cfg_bits[1];

   evtimer_main_ctr #(
      .W(REG_W)
   ) u_ctr (
      .clk  (clk),
      .rst  (rst),
      .run  (glb_enable),
      .wr   (wr_go && kind == RK_CTR),
      .wmask(lanes),
      .wdata(placed),
      .count(ctr_value)
   );

   // Per-timer write strobes
   for (genvar n = 0; n < NUM_TIMERS; n++) begin : g_tmr
      logic hit;
      assign hit             = wr_go && (tid == TID_W'(n));
      assign tmr_wr_cfg[n]   = hit && (kind == RK_TCFG);
      assign tmr_wr_cmp[n]   = hit && (kind == RK_TCMP);
      assign tmr_wr_route[n] = hit && (kind == RK_TROUTE);
   end

   assign tmr_wdata  = placed;
   assign tmr_wmask  = lanes;
   assign status_clr = (wr_go && kind == RK_STAT) ? clr_bits[NUM_TIMERS-1:0] : '0;

   // Read path
   always_comb begin
      reg_val = '0;
      unique case (kind)
         RK_CAP:    reg_val = CAP_VAL;
         RK_CFG:    reg_val = REG_W'(cfg_bits);
         RK_STAT:   reg_val = REG_W'(tmr_status);
         RK_CTR:    reg_val = ctr_value;
         RK_TCFG:   reg_val = tmr_cfg_q[int'(tid)*REG_W +: REG_W];
         RK_TCMP:   reg_val = tmr_cmp_q[int'(tid)*REG_W +: REG_W];
         RK_TROUTE: reg_val = tmr_route_q[int'(tid)*REG_W +: REG_W];
         default:   reg_val = '0;
      endcase
      bus_rdata = hi ? (reg_val >> HALF_W) : reg_val;
   end
endmodule

// File: rtl/evtimer_regs_chk.sv
module evtimer_regs_chk #(
   parameter int NUM_TIMERS = 3,
   parameter int ADDR_W     = 10,
   parameter int unsigned TICK_FS = 32'd10_000_000
) (
   input logic                  clk,
   input logic                  rst,
   input logic                  bus_valid,
   input logic                  bus_write,
   input logic [ADDR_W-1:0]     bus_addr,
   input logic [63:0]           bus_rdata,
   input logic                  glb_enable,
   input logic                  glb_legacy,
   input logic [63:0]           ctr_value,
   input logic [NUM_TIMERS-1:0] tmr_wr_cfg,
   input logic [NUM_TIMERS-1:0] tmr_wr_cmp,
   input logic [NUM_TIMERS-1:0] tmr_wr_route,
   input logic [NUM_TIMERS-1:0] status_clr
);
   logic        any_wr;
   logic [31:0] cap_lo_exp;
   assign any_wr     = bus_valid && bus_write;
   assign cap_lo_exp = 32'h8086_A001 | (32'(NUM_TIMERS - 1) << 8);

   a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (ctr_value == 64'd0 && !glb_enable && !glb_legacy));

   a_r2_cap_visible: assert property (@(posedge clk) disable iff (rst)
      (bus_addr == '0) |-> (bus_rdata == {TICK_FS[31:0], cap_lo_exp}));

   a_r4_cfg_only_by_write: assert property (@(posedge clk) disable iff (rst)
      !any_wr |=> $stable({glb_enable, glb_legacy}));

   a_r5_ctr_runs: assert property (@(posedge clk) disable iff (rst)
      (glb_enable && !any_wr) |=> (ctr_value == $past(ctr_value) + 64'd1));

   a_r5_ctr_holds: assert property (@(posedge clk) disable iff (rst)
      (!glb_enable && !any_wr) |=> $stable(ctr_value));

   a_r9_single_strobe: assert property (@(posedge clk) disable iff (rst)
      $onehot0({tmr_wr_cfg, tmr_wr_cmp, tmr_wr_route}));

   a_r8_quiet_without_write: assert property (@(posedge clk) disable iff (rst)
      !any_wr |-> ({tmr_wr_cfg, tmr_wr_cmp, tmr_wr_route, status_clr} == '0));
endmodule

bind evtimer_regs evtimer_regs_chk #(
   .NUM_TIMERS(NUM_TIMERS),
   .ADDR_W    (ADDR_W),
   .TICK_FS   (TICK_FS)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .bus_valid   (bus_valid),
   .bus_write   (bus_write),
   .bus_addr    (bus_addr),
   .bus_rdata   (bus_rdata),
   .glb_enable  (glb_enable),
   .glb_legacy  (glb_legacy),
   .ctr_value   (ctr_value),
   .tmr_wr_cfg  (tmr_wr_cfg),
   .tmr_wr_cmp  (tmr_wr_cmp),
   .tmr_wr_route(tmr_wr_route),
   .status_clr  (status_clr)
);

// File: tb/evtimer_regs_test.sv
`timescale 1ns/1ps
module evtimer_regs_test;
   localparam int N  = 3;
   localparam int AW = 10;
   localparam int NRD = 10;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          bus_valid = 1'b0, bus_write = 1'b0, bus_wide = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [63:0]   bus_wdata = '0;
   logic [63:0]   bus_rdata;
   logic [N-1:0]  tmr_status = 3'b101;
   logic [N*64-1:0] tmr_cfg_q, tmr_cmp_q, tmr_route_q;
   logic          glb_enable, glb_legacy;
   logic [63:0]   ctr_value, tmr_wdata, tmr_wmask;
   logic [N-1:0]  tmr_wr_cfg, tmr_wr_cmp, tmr_wr_route, status_clr;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   evtimer_regs #(.NUM_TIMERS(N), .ADDR_W(AW)) uut (
      .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_wide(bus_wide), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .tmr_status(tmr_status), .tmr_cfg_q(tmr_cfg_q),
      .tmr_cmp_q(tmr_cmp_q), .tmr_route_q(tmr_route_q), .glb_enable(glb_enable),
      .glb_legacy(glb_legacy), .ctr_value(ctr_value), .tmr_wr_cfg(tmr_wr_cfg),
      .tmr_wr_cmp(tmr_wr_cmp), .tmr_wr_route(tmr_wr_route), .tmr_wdata(tmr_wdata),
      .tmr_wmask(tmr_wmask), .status_clr(status_clr)
   );

   // Read table: address, expected bus_rdata
   localparam logic [AW-1:0] RD_ADDR [NRD] = '{
      10'h000, 10'h004, 10'h020, 10'h024, 10'h100,
      10'h128, 10'h12C, 10'h150, 10'h158, 10'h160 };
   localparam logic [63:0] RD_EXP [NRD] = '{
      64'h0098_9680_8086_A201, 64'h0000_0000_0098_9680,
      64'h0000_0000_0000_0005, 64'h0000_0000_0000_0000,
      64'hA000_0000_0000_00C0, 64'hB000_0001_0000_0D01,
      64'h0000_0000_B000_0001, 64'hE000_0002_000F_0002,
      64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000 };

   function automatic string rd_tag(input int i);
      case (i)
         0, 1:    return "R2";
         2, 3:    return "R8";
         6:       return "R3";
         9:       return "R10";
         default: return "R9";
      endcase
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [AW-1:0] a, input logic wide, input logic [63:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_wide = wide; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic bus_rd(input logic [AW-1:0] a, output logic [63:0] d);
      bus_write = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
   endtask

   // Drives a write, checks the combinational strobes before the edge
   task automatic strobe_wr(input logic [AW-1:0] a, input logic wide, input logic [63:0] d,
                            output logic [4*N-1:0] strobes);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_wide = wide; bus_addr = a; bus_wdata = d;
      #1 strobes = {tmr_wr_cfg, tmr_wr_cmp, tmr_wr_route, status_clr};
      @(posedge clk); #1;
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", checks, -1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [63:0] v, s1;
      logic [4*N-1:0] st;
      for (int n = 0; n < N; n++) begin
         tmr_cfg_q[n*64 +: 64]   = {32'hA000_0000 | 32'(n), 32'h0000_00C0 | 32'(n)};
         tmr_cmp_q[n*64 +: 64]   = {32'hB000_0000 | 32'(n), 32'h0000_0D00 | 32'(n)};
         tmr_route_q[n*64 +: 64] = {32'hE000_0000 | 32'(n), 32'h000F_0000 | 32'(n)};
      end
      repeat (4) @(posedge clk);
      #1 rst = 1'b0;

      // R1: reset state, and R5 hold while disabled
      bus_rd(10'h010, v); check("R1 cfg", v, 64'd0);
      bus_rd(10'h0F0, v); check("R1 counter", v, 64'd0);
      repeat (3) @(posedge clk); #1;
      bus_rd(10'h0F0, v); check("R5 held at reset value", v, 64'd0);

      // Read table
      for (int i = 0; i < NRD; i++) begin
         bus_rd(RD_ADDR[i], v);
         check(rd_tag(i), v, RD_EXP[i]);
      end

      // R6: full write while disabled, R5: held
      bus_wr(10'h0F0, 1'b1, 64'h0000_0001_FFFF_FFF0);
      bus_rd(10'h0F0, v); check("R6 full counter write", v, 64'h0000_0001_FFFF_FFF0);
      repeat (3) @(posedge clk); #1;
      bus_rd(10'h0F0, v); check("R5 disabled hold", v, 64'h0000_0001_FFFF_FFF0);

      // R4: reserved config bits
      bus_wr(10'h010, 1'b1, 64'hFFFF_FFFF_FFFF_FFFC);
      bus_rd(10'h010, v); check("R4 reserved bits", v, 64'd0);
      bus_wr(10'h014, 1'b0, 64'hFFFF_FFFF);
      bus_rd(10'h010, v); check("R4 upper half write", v, 64'd0);

      // R5: run 20 cycles, carry across 32 bits
      bus_wr(10'h010, 1'b0, 64'h3);
      check("R4 enable and legacy", {62'd0, glb_legacy, glb_enable}, 64'h3);
      repeat (20) @(posedge clk); #1;
      bus_rd(10'h0F0, v); check("R5 counting", v, 64'h0000_0002_0000_0004);
      bus_rd(10'h0F4, v); check("R3 counter upper half", v, 64'h2);

      // R6: half write while running wins, then resumes
      bus_wr(10'h0F0, 1'b0, 64'hDEAD_0000_0000_0100);
      bus_rd(10'h0F0, v); check("R6 low half write while enabled", v, 64'h0000_0002_0000_0100);
      @(posedge clk); #1;
      bus_rd(10'h0F0, v); check("R6 resume after write", v, 64'h0000_0002_0000_0101);
      bus_wr(10'h0F4, 1'b0, 64'h0000_0000_0000_0007);
      bus_rd(10'h0F4, v); check("R3 upper half counter write", v, 64'h7);

      // R5: disable then hold
      bus_wr(10'h010, 1'b0, 64'h2);
      bus_rd(10'h0F0, s1);
      repeat (5) @(posedge clk); #1;
      bus_rd(10'h0F0, v); check("R5 halted counter holds", v, s1);
      bus_wr(10'h010, 1'b0, 64'h1);
      @(posedge clk); #1;
      bus_rd(10'h0F0, v); check("R5 resumes from held value", v, s1 + 64'd1);
      bus_wr(10'h010, 1'b0, 64'h0);
      bus_rd(10'h0F0, s1);

      // R2 and R7: writes ignored
      bus_wr(10'h000, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
      bus_rd(10'h000, v); check("R2 capability write ignored", v, 64'h0098_9680_8086_A201);
      bus_wr(10'h018, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
      bus_wr(10'h0F8, 1'b1, 64'h0);
      bus_wr(10'h0F2, 1'b0, 64'h0);
      bus_rd(10'h010, v); check("R7 cfg untouched", v, 64'd0);
      bus_rd(10'h0F0, v); check("R7 counter untouched", v, s1);
      bus_rd(10'h030, v); check("R7 unmapped reads 0", v, 64'd0);

      // R9: strobes and placement
      strobe_wr(10'h12C, 1'b0, 64'h1234_5678, st);
      check("R9 cmp strobe timer1", 64'(st), {52'd0, 3'b000, 3'b010, 3'b000, 3'b000});
      check("R3 wdata placed high", tmr_wdata, 64'h1234_5678_0000_0000);
      check("R3 wmask high half", tmr_wmask, 64'hFFFF_FFFF_0000_0000);
      strobe_wr(10'h140, 1'b1, 64'h0123_4567_89AB_CDEF, st);
      check("R9 cfg strobe timer2", 64'(st), {52'd0, 3'b100, 3'b000, 3'b000, 3'b000});
      check("R9 full wdata", tmr_wdata, 64'h0123_4567_89AB_CDEF);
      check("R9 full wmask", tmr_wmask, 64'hFFFF_FFFF_FFFF_FFFF);
      strobe_wr(10'h110, 1'b0, 64'h55, st);
      check("R9 route strobe timer0", 64'(st), {52'd0, 3'b000, 3'b000, 3'b001, 3'b000});
      strobe_wr(10'h158, 1'b1, 64'h55, st);
      check("R9 offset 0x18 no strobe", 64'(st), 64'd0);
      strobe_wr(10'h160, 1'b1, 64'h55, st);
      check("R10 out of range no strobe", 64'(st), 64'd0);
      strobe_wr(10'h1E8, 1'b0, 64'h55, st);
      check("R10 far window no strobe", 64'(st), 64'd0);

      // R8: status clear pulse
      strobe_wr(10'h020, 1'b0, 64'h6, st);
      check("R8 status clear bits", 64'(st), {52'd0, 3'b000, 3'b000, 3'b000, 3'b110});
      #1 check("R8 pulse ends", 64'(status_clr), 64'd0);
      strobe_wr(10'h024, 1'b0, 64'h7, st);
      check("R8 upper half clears nothing", 64'(st), 64'd0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule